// File: doc/BRIEF.md
# Master-to-Frame Clock Ratio Detector

This block runs on the master clock of an audio converter front end. It measures how many master-clock cycles make up one frame of the left/right frame clock. It classifies that count as one of three accepted ratios (256, 384 or 512) or as invalid. Downstream, the bit-clock generator uses the ratio code to choose its division. The mute sequencer uses the valid flag and the one-cycle fault pulse to silence the outputs and to start a soft ramp.

A new ratio is accepted only after two consecutive frames measure the same accepted value. Three events drop an accepted ratio and pulse the fault output: a frame of a different accepted length, a frame of any other length, or a frame clock that stops toggling. A separate watchdog runs on a free-running reference clock. It watches a toggle flag driven by the master clock and raises a loss flag when the toggling stops.

Top module: `mclk_ratio_detect`

## Requirements
- R1: After reset the ratio code is 2'b11, the valid flag is 0 and the fault pulse is 0.
- R2: A frame is measured from one rising edge of `lrclk` to the next, in master-clock cycles. The first rising edge after reset only starts a measurement. A length of exactly 256 gives code 2'b00, 384 gives 2'b01 and 512 gives 2'b10. Every other length gives the invalid code 2'b11, including lengths one cycle off an accepted value.
- R3: The valid flag rises only when two consecutive measured frames give the same accepted code. While valid is high, `ratio_code` shows that code. While valid is low, `ratio_code` is 2'b11.
- R4: While valid, a frame of a different accepted length drops valid and pulses the fault output. The new ratio is accepted at the end of the next frame of the same length.
- R5: While valid, a frame of an invalid length drops valid and pulses the fault output. Acceptance then needs two further matching frames.
- R6: The running count saturates at 576 master cycles (512 plus a margin of 64). Reaching saturation is a loss of the frame clock. The loss drops valid and pulses fault before the next rising edge. A frame of 575 cycles is measured as invalid instead. The first rising edge after a loss starts a new measurement without classifying.
- R7: The fault output is high for exactly one cycle, and only in the cycle in which valid falls from 1 to 0.
- R8: `mclk_lost`, in the reference domain, sets when no master-clock toggle has been seen for 16 reference cycles. It clears once toggling resumes.
- R9: While valid, frames of the same accepted length keep valid high and raise no fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset, master domain |
| lrclk | input | 1 | Frame clock, synchronous to mclk |
| ref_clk | input | 1 | Free-running reference clock for the watchdog |
| ref_rst_n | input | 1 | Active-low synchronous reset, reference domain |
| ratio_code | output | 2 | 00 = 256, 01 = 384, 10 = 512, 11 = invalid/none |
| ratio_valid | output | 1 | Ratio confirmed by two matching frames |
| clk_fault | output | 1 | One-cycle pulse when a confirmed ratio is lost |
| mclk_lost | output | 1 | Master clock has stopped (reference domain) |

## Verification
The hardest situation to reach from the ports is the saturation boundary. A frame of 575 cycles must be classified as invalid, while a frame of 576 or more is a loss and must not be classified at all. Each case must also start from a confirmed ratio, so that the fault pulse is observable. The stimulus first brings the block to valid with directed runs of 384-cycle frames, then drives 575, 576 and 700-cycle frames. It checks the 700-cycle frame inside the frame, after saturation and before the next edge. Master-clock loss is reached by gating the bench master clock off for many reference periods and then restarting it.

// File: rtl/ratio_pkg.sv
`timescale 1ns/1ps
package ratio_pkg;

  localparam logic [1:0] RC_256 = 2'b00;
  localparam logic [1:0] RC_384 = 2'b01;
  localparam logic [1:0] RC_512 = 2'b10;
  localparam logic [1:0] RC_INV = 2'b11;

  localparam int unsigned LEN_256 = 256;
  localparam int unsigned LEN_384 = 384;
  localparam int unsigned LEN_512 = 512;

  // Map a measured frame length to its ratio code.
  function automatic logic [1:0] classify_period(input int unsigned len);
    if (len == LEN_256)      return RC_256;
    else if (len == LEN_384) return RC_384;
    else if (len == LEN_512) return RC_512;
    else                     return RC_INV;
  endfunction

endpackage

// File: rtl/frame_counter.sv
`timescale 1ns/1ps
module frame_counter #(
  parameter int SAT_LIMIT = 576,
  localparam int CNT_W = $clog2(SAT_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lrclk,
  output logic             period_vld,
  output logic [CNT_W-1:0] period_val,
  output logic             lr_lost
);

  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT_LIMIT);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic             lr_q;
  logic [CNT_W-1:0] cnt;
  logic             rise;
  logic             at_sat;

  assign rise   = lrclk & ~lr_q;
  assign at_sat = (cnt == SAT_V);

  // The count starts saturated, so the first rise after reset only arms it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_q       <= 1'b0;
      cnt        <= SAT_V;
      period_vld <= 1'b0;
      period_val <= '0;
      lr_lost    <= 1'b0;
    end else begin
      lr_q       <= lrclk;
      period_vld <= rise & ~at_sat;
      if (rise && !at_sat) period_val <= cnt;
      lr_lost    <= ~rise & (cnt == SAT_V - ONE_V);
      if (rise)         cnt <= ONE_V;
      else if (!at_sat) cnt <= cnt + ONE_V;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= SAT_V);

  p_lost_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lr_lost |=> !lr_lost);

  p_lost_excludes_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(lr_lost && period_vld));

endmodule

// File: rtl/ratio_classifier.sv
`timescale 1ns/1ps
module ratio_classifier
  import ratio_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_vld,
  input  logic [CNT_W-1:0] period_val,
  input  logic             lr_lost,
  output logic [1:0]       ratio_code,
  output logic             ratio_valid,
  output logic             clk_fault
);

  logic [1:0] code_now;
  logic [1:0] prev_code;
  logic       drop;
  logic       confirm;

  assign code_now = classify_period(32'(period_val));
  assign drop     = ratio_valid & (lr_lost | (period_vld & (code_now != ratio_code)));
  assign confirm  = ~ratio_valid & period_vld & (code_now != RC_INV) & (code_now == prev_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_code  <= RC_INV;
      ratio_valid <= 1'b0;
      clk_fault   <= 1'b0;
      prev_code   <= RC_INV;
    end else begin
      clk_fault <= drop;
      if (drop) begin
        ratio_valid <= 1'b0;
        ratio_code  <= RC_INV;
      end else if (confirm) begin
        ratio_valid <= 1'b1;
        ratio_code  <= code_now;
      end
      if (lr_lost)         prev_code <= RC_INV;
      else if (period_vld) prev_code <= code_now;
    end
  end

  p_code_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_valid |-> (ratio_code == RC_INV));

  p_valid_after_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_valid) |-> $past(period_vld));

  p_fault_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fault |-> (!ratio_valid && $past(ratio_valid)));

  p_fall_gives_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ratio_valid) |-> clk_fault);

  p_code_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_valid && $past(ratio_valid)) |-> $stable(ratio_code));

endmodule

// File: rtl/mclk_watchdog.sv
`timescale 1ns/1ps
module mclk_watchdog #(
  parameter int REF_TIMEOUT = 16,
  localparam int TW = $clog2(REF_TIMEOUT + 1)
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic ref_clk,
  input  logic ref_rst_n,
  output logic mclk_lost
);

  localparam logic [TW-1:0] LIM   = TW'(REF_TIMEOUT);
  localparam logic [TW-1:0] ONE_T = TW'(1);

  logic          tgl;
  logic [2:0]    sync;
  logic          seen;
  logic [TW-1:0] idle;

  always_ff @(posedge mclk) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end

  assign seen = sync[2] ^ sync[1];

  always_ff @(posedge ref_clk) begin
    if (!ref_rst_n) begin
      sync      <= '0;
      idle      <= '0;
      mclk_lost <= 1'b0;
    end else begin
      sync <= {sync[1:0], tgl};
      if (seen)             idle <= '0;
      else if (idle != LIM) idle <= idle + ONE_T;
      mclk_lost <= ~seen & (mclk_lost | (idle == LIM - ONE_T));
    end
  end

  p_idle_bound_r8: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    idle <= LIM);

  p_clear_on_toggle_r8: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    seen |=> !mclk_lost);

  p_set_after_timeout_r8: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(mclk_lost) |-> ($past(idle) == LIM - ONE_T));

endmodule

// File: rtl/mclk_ratio_detect.sv
`timescale 1ns/1ps
module mclk_ratio_detect #(
  parameter int SAT_MARGIN  = 64,
  parameter int REF_TIMEOUT = 16,
  localparam int SAT_LIMIT  = 512 + SAT_MARGIN,
  localparam int CNT_W      = $clog2(SAT_LIMIT + 1)
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       lrclk,
  input  logic       ref_clk,
  input  logic       ref_rst_n,
  output logic [1:0] ratio_code,
  output logic       ratio_valid,
  output logic       clk_fault,
  output logic       mclk_lost
);

  logic             period_vld;
  logic [CNT_W-1:0] period_val;
  logic             lr_lost;

  frame_counter #(.SAT_LIMIT(SAT_LIMIT)) u_count (
    .clk        (mclk),
    .rst_n      (rst_n),
    .lrclk      (lrclk),
    .period_vld (period_vld),
    .period_val (period_val),
    .lr_lost    (lr_lost)
  );

  ratio_classifier #(.CNT_W(CNT_W)) u_class (
    .clk         (mclk),
    .rst_n       (rst_n),
    .period_vld  (period_vld),
    .period_val  (period_val),
    .lr_lost     (lr_lost),
    .ratio_code  (ratio_code),
    .ratio_valid (ratio_valid),
    .clk_fault   (clk_fault)
  );

  mclk_watchdog #(.REF_TIMEOUT(REF_TIMEOUT)) u_wdog (
    .mclk      (mclk),
    .rst_n     (rst_n),
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .mclk_lost (mclk_lost)
  );

endmodule

// File: tb/mclk_ratio_detect_bench.sv
`timescale 1ns/1ps
module mclk_ratio_detect_bench;

  localparam int SAT = 576;

  logic       mclk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_rst_n = 1'b0;
  logic       lrclk = 1'b0;
  logic [1:0] ratio_code;
  logic       ratio_valid;
  logic       clk_fault;
  logic       mclk_lost;
  bit         run = 1'b1;

  int checks = 0;
  int errors = 0;
  int fault_seen = 0;
  int fault_wide = 0;
  int fault_exp = 0;
  bit fault_q = 1'b0;

  // model state
  int prev_len = -1;
  bit m_valid = 1'b0;
  int m_code = 3;
  int m_prev = 3;

  mclk_ratio_detect u_mclk_ratio_detect (
    .mclk(mclk), .rst_n(rst_n), .lrclk(lrclk), .ref_clk(ref_clk),
    .ref_rst_n(ref_rst_n), .ratio_code(ratio_code), .ratio_valid(ratio_valid),
    .clk_fault(clk_fault), .mclk_lost(mclk_lost)
  );

  always begin
    #2;
    if (run) mclk = ~mclk;
  end

  initial begin
    #1;
    forever #10 ref_clk = ~ref_clk;
  end

  always @(negedge mclk) begin
    if (clk_fault) fault_seen++;
    if (clk_fault && fault_q) fault_wide++;
    fault_q = clk_fault;
  end

  function automatic int ref_code(input int len);
    case (len)
      256: return 0;
      384: return 1;
      512: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Apply the rising edge that ends the previous frame to the model.
  task automatic model_rise(output string tag);
    int c;
    tag = "R2";
    if (prev_len >= SAT) begin
      tag = "R6";
      if (m_valid) fault_exp++;
      m_valid = 1'b0; m_code = 3; m_prev = 3;
    end else if (prev_len > 0) begin
      c = ref_code(prev_len);
      if (m_valid && c != m_code) begin
        tag = (c == 3) ? "R5" : "R4";
        fault_exp++;
        m_valid = 1'b0; m_code = 3;
      end else if (m_valid) begin
        tag = "R9";
      end else if (c != 3 && c == m_prev) begin
        tag = "R3";
        m_valid = 1'b1; m_code = c;
      end
      m_prev = c;
    end
  endtask

  task automatic do_frame(input int n);
    string tag;
    int h;
    h = n / 2;
    @(negedge mclk);
    lrclk = 1'b1;
    model_rise(tag);
    for (int i = 1; i <= 4; i++) @(negedge mclk);
    chk(ratio_code == 2'(m_code), {tag, " code"}, ratio_code, m_code);
    chk(ratio_valid == m_valid, {tag, " valid"}, ratio_valid, m_valid);
    chk(fault_seen == fault_exp, {tag, " fault count"}, fault_seen, fault_exp);
    for (int i = 5; i < n; i++) begin
      @(negedge mclk);
      if (i == h) lrclk = 1'b0;
      if (n > SAT + 8 && i == SAT + 3) begin
        // R6: saturation inside the frame has already dropped valid
        chk(ratio_valid == 1'b0, "R6 mid-frame valid", ratio_valid, 0);
        chk(ratio_code == 2'b11, "R6 mid-frame code", ratio_code, 3);
      end
    end
    prev_len = n;
  endtask

  initial begin
    #(800_000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int picks [12] = '{256, 384, 512, 256, 384, 512, 255, 257, 383, 513, 575, 640};
    int r;
    r = $urandom(32'd20240611);
    repeat (5) @(negedge mclk);
    rst_n = 1'b1;
    ref_rst_n = 1'b1;
    @(negedge mclk);
    // R1 reset state
    chk(ratio_code == 2'b11, "R1 code", ratio_code, 3);
    chk(ratio_valid == 1'b0, "R1 valid", ratio_valid, 0);
    chk(clk_fault == 1'b0, "R1 fault", clk_fault, 0);

    // R2/R3 acceptance, R9 steady, R4 change
    do_frame(256); do_frame(256); do_frame(256); do_frame(256);
    do_frame(512); do_frame(512); do_frame(512);
    do_frame(384); do_frame(384); do_frame(384);
    // R5 invalid (one off)
    do_frame(383); do_frame(384); do_frame(384); do_frame(384);
    do_frame(385); do_frame(384); do_frame(384);
    // R6 boundary: 575 invalid, 576 loss, 700 loss seen mid-frame
    do_frame(575); do_frame(384); do_frame(384); do_frame(384);
    do_frame(576); do_frame(384); do_frame(384); do_frame(384);
    do_frame(700); do_frame(256); do_frame(256); do_frame(256);

    // constrained random mix
    for (int k = 0; k < 40; k++) begin
      int len;
      int rep;
      len = picks[$urandom % 12];
      rep = 1 + ($urandom % 3);
      for (int j = 0; j < rep; j++) do_frame(len);
    end
    do_frame(256);

    // R7 pulse width
    chk(fault_wide == 0, "R7 fault wider than one cycle", fault_wide, 0);
    chk(fault_seen > 0, "R7 faults observed", fault_seen, 1);

    // R8 master clock loss
    chk(mclk_lost == 1'b0, "R8 running", mclk_lost, 0);
    @(negedge mclk);
    run = 1'b0;
    #(40 * 20);
    chk(mclk_lost == 1'b1, "R8 stopped", mclk_lost, 1);
    run = 1'b1;
    #(20 * 20);
    chk(mclk_lost == 1'b0, "R8 resumed", mclk_lost, 0);

    finish_run();
  end

endmodule